// File: doc/BRIEF.md
# OTP Block Program Sequencer

This block is a host-side sequencer that programs the one-time-programmable block of a NAND flash device whose control is register-mapped. It masters a simple synchronous register bus (address, write data, read data, write strobe, read strobe, acknowledge). It moves only one access at a time, and it waits for the acknowledge before it starts the next access.

A start pulse launches a fixed script. The script first sets up the device: it selects the buffer and the die, sets the block address and enters OTP access. It then loads the page, sector and buffer geometry. Next it copies a fixed number of payload words from a valid/ready input stream into the device buffer RAM. It then issues the program command and polls the interrupt register until bit 15 rises. After that it reads the controller status to decide pass or error. Last, it issues a reset command to leave OTP mode and polls once more for that reset to finish. When auto-interrupt mode is not selected, the interrupt register is cleared after each poll.

A programmable cycle limit bounds every poll. On expiry the run is abandoned and a timeout is reported. When a run ends the block gives a one-cycle done pulse, and exactly one of pass, error or timeout is raised. That flag stays up until the next accepted start.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset, busy_o, done_o, pass_o, err_o, tmo_o, dat_ready_o, bus_we_o and bus_re_o are all 0.
- R2: Writes occur in this order: 0xF101=0x0000, 0xF100={1'b0, blk_addr_i[14:0]}, 0xF220=0x0065, 0xF107=pg_sec_i, 0xF200=buf_cfg_i, then N_WORDS payload words to BUF_BASE+k (k=0..N_WORDS-1), then the program command to 0xF220.
- R3: The program command is 0x0080 when cmd_sel_i=0 and 0x001A when cmd_sel_i=1.
- R4: Only one strobe is high at a time. A strobe, its address and its write data stay stable until bus_ack_i. After an acknowledged cycle both strobes are low for at least one cycle.
- R5: dat_ready_o is high only while the block waits for a payload word with no bus access in flight. A word is taken on dat_valid_i && dat_ready_o, and it lands at the next buffer address in stream order, whatever the gaps in valid.
- R6: A poll completes only on a read of 0xF241 with bit 15 = 1 that follows an earlier read in the same poll with bit 15 = 0. A stale high at the start of the poll is ignored.
- R7: After the first poll, 0xF240 is read exactly once. If bit 10 is 1 the run ends with err_o = 1; if bit 10 is 0 it ends with pass_o = 1.
- R8: When auto_int_i = 0, 0x0000 is written to 0xF241 after each completed poll. When auto_int_i = 1 no write to 0xF241 occurs.
- R9: After the status read (and any clear), the block writes the reset command to 0xF220: 0x00F0 (core) when rst_sel_i=0, 0x00F3 (hot) when rst_sel_i=1. It then polls 0xF241 a second time before it reports done.
- R10: If a poll reaches tmo_lim_i cycles without completing, the run ends with tmo_o = 1 and issues no further bus access: no status read and no reset command.
- R11: done_o is a single-cycle pulse, and exactly one of pass_o/err_o/tmo_o is set when it fires. These flags hold until the next accepted start and are cleared in the cycle that start is accepted.
- R12: start_i is ignored while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| cmd_sel_i | input | 1 | Program command select |
| auto_int_i | input | 1 | Auto-interrupt mode: skip interrupt clears |
| rst_sel_i | input | 1 | Exit reset select: core or hot |
| blk_addr_i | input | 16 | Target block address (bit 15 forced to 0) |
| pg_sec_i | input | 16 | Page and sector address value |
| buf_cfg_i | input | 16 | Buffer sector and count value |
| tmo_lim_i | input | TMO_W | Poll cycle limit |
| dat_valid_i | input | 1 | Payload word valid |
| dat_i | input | DW | Payload word |
| dat_ready_o | output | 1 | Payload word accepted when valid |
| bus_addr_o | output | AW | Register bus address |
| bus_wdata_o | output | DW | Register bus write data |
| bus_we_o | output | 1 | Write strobe |
| bus_re_o | output | 1 | Read strobe |
| bus_rdata_i | input | DW | Register bus read data |
| bus_ack_i | input | 1 | Access acknowledge |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Run passed |
| err_o | output | 1 | Device reported error |
| tmo_o | output | 1 | Poll timed out |

## Verification
The bench targets an interrupt register that still reads high right after the program command. A sequencer that took that stale high as completion would read status too early and do fewer interrupt reads than the model demands. A device that never completes must end in a timeout with no status read and no reset command; a design that let the abort fall through would be caught writing the reset. Further runs cover a die-select bit set on the block input, a payload stream with gaps, slow acknowledges, auto-interrupt mode (no clear writes may appear) and a start pulse mid-run (a restart would repeat the setup writes). Each command-select and reset-select value is checked at the exact position of its write in the logged sequence.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_SEL, S_BLK, S_OTP, S_PG, S_BUF, S_DAT, S_PRG,
    S_POLL1, S_STAT, S_CLR1, S_RST, S_POLL2, S_CLR2, S_FIN
  } step_e;

  localparam logic [15:0] A_BUFSEL = 16'hF101;
  localparam logic [15:0] A_BLK    = 16'hF100;
  localparam logic [15:0] A_PGSEC  = 16'hF107;
  localparam logic [15:0] A_BUFCFG = 16'hF200;
  localparam logic [15:0] A_CMD    = 16'hF220;
  localparam logic [15:0] A_STAT   = 16'hF240;
  localparam logic [15:0] A_INT    = 16'hF241;

  localparam logic [15:0] C_OTP      = 16'h0065;
  localparam logic [15:0] C_PRG_A    = 16'h0080;
  localparam logic [15:0] C_PRG_B    = 16'h001A;
  localparam logic [15:0] C_RST_CORE = 16'h00F0;
  localparam logic [15:0] C_RST_HOT  = 16'h00F3;

  localparam int INT_BIT = 15;
  localparam int ERR_BIT = 10;
endpackage

// File: rtl/otp_bus_port.sv
module otp_bus_port #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic          bus_we_o,
  output logic          bus_re_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ack_i
);
  logic          act_q, we_q, done_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!act_q && req_i) begin
        act_q   <= 1'b1;
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end else if (act_q && bus_ack_i) begin
        act_q   <= 1'b0;
        done_q  <= 1'b1;
        rdata_q <= bus_rdata_i;
      end
    end
  end

  assign bus_we_o    = act_q && we_q;
  assign bus_re_o    = act_q && !we_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/otp_int_watch.sv
module otp_int_watch #(
  parameter int DW      = 16,
  parameter int TMO_W   = 16,
  parameter int INT_BIT = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             smp_i,
  input  logic [DW-1:0]    data_i,
  input  logic [TMO_W-1:0] lim_i,
  output logic             rise_o,
  output logic             exp_o
);
  localparam logic [TMO_W-1:0] CNT_MAX = '1;

  logic             seen_low_q;
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_low_q <= 1'b0;
      cnt_q      <= '0;
    end else if (clr_i) begin
      seen_low_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      if (en_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (smp_i && !data_i[INT_BIT]) seen_low_q <= 1'b1;
    end
  end

  // completion needs a low sample earlier in this poll
  assign rise_o = smp_i && data_i[INT_BIT] && seen_low_q;
  assign exp_o  = cnt_q >= lim_i;
endmodule

// File: rtl/otp_step_map.sv
module otp_step_map
  import otp_seq_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 16,
  parameter int          WIW      = 3,
  parameter logic [15:0] BUF_BASE = 16'h0200
) (
  input  step_e          step_i,
  input  logic [WIW-1:0] widx_i,
  input  logic [DW-1:0]  dat_i,
  input  logic [15:0]    blk_addr_i,
  input  logic [15:0]    pg_sec_i,
  input  logic [15:0]    buf_cfg_i,
  input  logic           cmd_sel_i,
  input  logic           rst_sel_i,
  output logic [AW-1:0]  addr_o,
  output logic [DW-1:0]  wdata_o,
  output logic           we_o
);
  always_comb begin
    addr_o  = '0;
    wdata_o = '0;
    we_o    = 1'b1;
    unique case (step_i)
      S_SEL: addr_o = AW'(A_BUFSEL);
      S_BLK: begin
        addr_o  = AW'(A_BLK);
        wdata_o = DW'({1'b0, blk_addr_i[14:0]});
      end
      S_OTP: begin
        addr_o  = AW'(A_CMD);
        wdata_o = DW'(C_OTP);
      end
      S_PG: begin
        addr_o  = AW'(A_PGSEC);
        wdata_o = DW'(pg_sec_i);
      end
      S_BUF: begin
        addr_o  = AW'(A_BUFCFG);
        wdata_o = DW'(buf_cfg_i);
      end
      S_DAT: begin
        addr_o  = AW'(BUF_BASE) + AW'(widx_i);
        wdata_o = dat_i;
      end
      S_PRG: begin
        addr_o  = AW'(A_CMD);
        wdata_o = DW'(cmd_sel_i ? C_PRG_B : C_PRG_A);
      end
      S_POLL1, S_POLL2: begin
        addr_o = AW'(A_INT);
        we_o   = 1'b0;
      end
      S_STAT: begin
        addr_o = AW'(A_STAT);
        we_o   = 1'b0;
      end
      S_CLR1, S_CLR2: addr_o = AW'(A_INT);
      S_RST: begin
        addr_o  = AW'(A_CMD);
        wdata_o = DW'(rst_sel_i ? C_RST_HOT : C_RST_CORE);
      end
      default: we_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_seq_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 16,
  parameter int          N_WORDS  = 8,
  parameter int          TMO_W    = 16,
  parameter logic [15:0] BUF_BASE = 16'h0200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmd_sel_i,
  input  logic             auto_int_i,
  input  logic             rst_sel_i,
  input  logic [15:0]      blk_addr_i,
  input  logic [15:0]      pg_sec_i,
  input  logic [15:0]      buf_cfg_i,
  input  logic [TMO_W-1:0] tmo_lim_i,
  input  logic             dat_valid_i,
  input  logic [DW-1:0]    dat_i,
  output logic             dat_ready_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [DW-1:0]    bus_wdata_o,
  output logic             bus_we_o,
  output logic             bus_re_o,
  input  logic [DW-1:0]    bus_rdata_i,
  input  logic             bus_ack_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             pass_o,
  output logic             err_o,
  output logic             tmo_o
);
  localparam int WIW = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam logic [WIW-1:0] LAST_W = WIW'(N_WORDS - 1);

  step_e          state_q;
  logic           wait_q, stat_err_q;
  logic [WIW-1:0] widx_q;
  logic           req, issuing, in_poll, bus_done, poll_clr, rise, expd;
  logic           step_we;
  logic [AW-1:0]  step_addr;
  logic [DW-1:0]  step_wdata, rdata;

  assign issuing = !(state_q inside {S_IDLE, S_FIN});
  assign in_poll = state_q inside {S_POLL1, S_POLL2};
  assign req     = issuing && !wait_q && (state_q != S_DAT || dat_valid_i);
  assign poll_clr = bus_done && (state_q inside {S_PRG, S_RST});

  otp_step_map #(.AW(AW), .DW(DW), .WIW(WIW), .BUF_BASE(BUF_BASE)) u_map (
    .step_i     (state_q),
    .widx_i     (widx_q),
    .dat_i      (dat_i),
    .blk_addr_i (blk_addr_i),
    .pg_sec_i   (pg_sec_i),
    .buf_cfg_i  (buf_cfg_i),
    .cmd_sel_i  (cmd_sel_i),
    .rst_sel_i  (rst_sel_i),
    .addr_o     (step_addr),
    .wdata_o    (step_wdata),
    .we_o       (step_we)
  );

  otp_bus_port #(.AW(AW), .DW(DW)) u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req),
    .we_i        (step_we),
    .addr_i      (step_addr),
    .wdata_i     (step_wdata),
    .done_o      (bus_done),
    .rdata_o     (rdata),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_we_o    (bus_we_o),
    .bus_re_o    (bus_re_o),
    .bus_rdata_i (bus_rdata_i),
    .bus_ack_i   (bus_ack_i)
  );

  otp_int_watch #(.DW(DW), .TMO_W(TMO_W), .INT_BIT(INT_BIT)) u_watch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (poll_clr),
    .en_i   (in_poll),
    .smp_i  (bus_done && in_poll),
    .data_i (rdata),
    .lim_i  (tmo_lim_i),
    .rise_o (rise),
    .exp_o  (expd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      wait_q     <= 1'b0;
      widx_q     <= '0;
      stat_err_q <= 1'b0;
      pass_o     <= 1'b0;
      err_o      <= 1'b0;
      tmo_o      <= 1'b0;
    end else begin
      if (req) wait_q <= 1'b1;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_SEL;
          widx_q  <= '0;
          pass_o  <= 1'b0;
          err_o   <= 1'b0;
          tmo_o   <= 1'b0;
        end
        S_FIN: state_q <= S_IDLE;
        default: if (bus_done) begin
          wait_q <= 1'b0;
          unique case (state_q)
            S_SEL: state_q <= S_BLK;
            S_BLK: state_q <= S_OTP;
            S_OTP: state_q <= S_PG;
            S_PG:  state_q <= S_BUF;
            S_BUF: state_q <= S_DAT;
            S_DAT: begin
              widx_q <= widx_q + 1'b1;
              if (widx_q == LAST_W) state_q <= S_PRG;
            end
            S_PRG: state_q <= S_POLL1;
            S_POLL1: begin
              if (rise)      state_q <= S_STAT;
              else if (expd) begin
                state_q <= S_FIN;
                tmo_o   <= 1'b1;
              end
            end
            S_STAT: begin
              stat_err_q <= rdata[ERR_BIT];
              state_q    <= auto_int_i ? S_RST : S_CLR1;
            end
            S_CLR1: state_q <= S_RST;
            S_RST:  state_q <= S_POLL2;
            S_POLL2: begin
              if (rise) begin
                if (auto_int_i) begin
                  state_q <= S_FIN;
                  pass_o  <= !stat_err_q;
                  err_o   <= stat_err_q;
                end else begin
                  state_q <= S_CLR2;
                end
              end else if (expd) begin
                state_q <= S_FIN;
                tmo_o   <= 1'b1;
              end
            end
            S_CLR2: begin
              state_q <= S_FIN;
              pass_o  <= !stat_err_q;
              err_o   <= stat_err_q;
            end
            default: state_q <= S_IDLE;
          endcase
        end
      endcase
    end
  end

  assign dat_ready_o = (state_q == S_DAT) && !wait_q;
  assign busy_o      = state_q != S_IDLE;
  assign done_o      = state_q == S_FIN;
endmodule

// File: rtl/otp_seq_chk.sv
module otp_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          dat_ready_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [DW-1:0] bus_wdata_o,
  input logic          bus_we_o,
  input logic          bus_re_o,
  input logic          bus_ack_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          pass_o,
  input logic          err_o,
  input logic          tmo_o
);
  p_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_o && bus_re_o));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o || bus_re_o) && !bus_ack_i |=>
      (bus_we_o || bus_re_o) && $stable(bus_addr_o) && $stable(bus_wdata_o) && $stable(bus_we_o));

  p_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o || bus_re_o) && bus_ack_i |=> !bus_we_o && !bus_re_o);

  p_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_ready_o |-> !bus_we_o && !bus_re_o && busy_o);

  p_tmo_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> !bus_we_o && !bus_re_o);

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_one_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones({pass_o, err_o, tmo_o}) == 1);

  p_flag_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o || err_o || tmo_o) && !start_i |=> $stable({pass_o, err_o, tmo_o}));

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_we_o && !bus_re_o && !done_o);
endmodule

bind otp_prog_seq otp_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .dat_ready_o (dat_ready_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_we_o    (bus_we_o),
  .bus_re_o    (bus_re_o),
  .bus_ack_i   (bus_ack_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .pass_o      (pass_o),
  .err_o       (err_o),
  .tmo_o       (tmo_o)
);

// File: tb/sim_otp_prog_seq.sv
`timescale 1ns/1ps
module sim_otp_prog_seq;
  localparam int NW = 8;
  localparam int TW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, cmd_sel = 0, auto_int = 0, rst_sel = 0;
  logic [15:0] blk = 0, pgs = 0, bcfg = 0;
  logic [TW-1:0] lim = 16'd1000;
  logic dvalid = 0;
  logic [15:0] din = 0;
  logic dready;
  logic [15:0] baddr, bwdata, brdata;
  logic bwe, bre, back;
  logic busy, done, pass, err, tmo;

  always #5 clk = ~clk;

  otp_prog_seq #(.N_WORDS(NW), .TMO_W(TW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_sel_i(cmd_sel),
    .auto_int_i(auto_int), .rst_sel_i(rst_sel), .blk_addr_i(blk),
    .pg_sec_i(pgs), .buf_cfg_i(bcfg), .tmo_lim_i(lim),
    .dat_valid_i(dvalid), .dat_i(din), .dat_ready_o(dready),
    .bus_addr_o(baddr), .bus_wdata_o(bwdata), .bus_we_o(bwe), .bus_re_o(bre),
    .bus_rdata_i(brdata), .bus_ack_i(back),
    .busy_o(busy), .done_o(done), .pass_o(pass), .err_o(err), .tmo_o(tmo)
  );

  int n_tests = 0, n_fail = 0;

  // device model
  int lat = 0, lat_cnt = 0, stale_cfg = 0, lo_cfg = 1, stale_n = 0, lo_n = 0;
  bit hang = 0;
  logic [15:0] stat_val = 0;
  logic [15:0] log_a [0:63];
  logic [15:0] log_d [0:63];
  bit          log_w [0:63];
  int log_n = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      back <= 1'b0; brdata <= '0; lat_cnt = 0;
    end else if (back) begin
      back <= 1'b0; lat_cnt = 0;
    end else if (bwe || bre) begin
      if (lat_cnt >= lat) begin
        back <= 1'b1;
        if (log_n < 64) begin
          log_a[log_n] = baddr; log_d[log_n] = bwe ? bwdata : 16'h0; log_w[log_n] = bwe;
          log_n++;
        end
        if (bwe && baddr == 16'hF220 &&
            (bwdata == 16'h0080 || bwdata == 16'h001A || bwdata == 16'h00F0 || bwdata == 16'h00F3)) begin
          stale_n = stale_cfg; lo_n = lo_cfg;
        end
        if (bre && baddr == 16'hF241) begin
          if (stale_n > 0) begin stale_n--; brdata <= 16'h8000; end
          else if (lo_n > 0 || hang) begin if (lo_n > 0) lo_n--; brdata <= 16'h0000; end
          else brdata <= 16'h8000;
        end else if (bre && baddr == 16'hF240) brdata <= stat_val;
        else brdata <= 16'h0;
      end else lat_cnt++;
    end
  end

  // payload feeder
  logic [15:0] words [0:NW-1];
  int feed_idx = 0, cyc = 0;
  bit gaps = 0;
  always @(negedge clk) begin
    cyc++;
    if (feed_idx < NW) begin
      dvalid = gaps ? (cyc % 3 != 0) : 1'b1;
      din = words[feed_idx];
    end else begin
      dvalid = 1'b0; din = 16'h0;
    end
  end
  always @(posedge clk) if (dvalid && dready) feed_idx <= feed_idx + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_all();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
    if (!ok) chk(0, "watchdog done_o", 0, 1);
  endtask

  // runs one operation and checks the bus log against the required order
  task automatic run_op(input bit cs, input bit ai, input bit rs, input logic [15:0] sv,
                        input int l, input int st, input int lo, input bit hg,
                        input bit gp, input bit restart, input string name);
    logic [15:0] ea [0:31];
    logic [15:0] ed [0:31];
    int en = 0, wn = 0, rd241 = 0, rd240 = 0, idx240 = -1, idx_rst = -1;
    bit ok;
    cmd_sel = cs; auto_int = ai; rst_sel = rs; stat_val = sv; lat = l;
    stale_cfg = st; lo_cfg = lo; hang = hg; gaps = gp;
    blk = 16'h8123 + 16'(l); pgs = 16'h0104 + 16'(st); bcfg = 16'h0801 + 16'(lo);
    for (int k = 0; k < NW; k++) words[k] = 16'hA500 + 16'(k * 13) + 16'(l * 7);
    log_n = 0; feed_idx = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy && !pass && !err && !tmo, {name, " R11 flags cleared on start"}, {busy, pass, err, tmo}, 4'b1000);
    if (restart) begin
      repeat (12) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    wait_done(ok);
    if (!ok) finish_all();
    // expected write list (R2, R3, R8, R9)
    ea[en] = 16'hF101; ed[en++] = 16'h0000;
    ea[en] = 16'hF100; ed[en++] = {1'b0, blk[14:0]};
    ea[en] = 16'hF220; ed[en++] = 16'h0065;
    ea[en] = 16'hF107; ed[en++] = pgs;
    ea[en] = 16'hF200; ed[en++] = bcfg;
    for (int k = 0; k < NW; k++) begin ea[en] = 16'h0200 + 16'(k); ed[en++] = words[k]; end
    ea[en] = 16'hF220; ed[en++] = cs ? 16'h001A : 16'h0080;
    if (!hg) begin
      if (!ai) begin ea[en] = 16'hF241; ed[en++] = 16'h0000; end
      ea[en] = 16'hF220; ed[en++] = rs ? 16'h00F3 : 16'h00F0;
      if (!ai) begin ea[en] = 16'hF241; ed[en++] = 16'h0000; end
    end
    for (int i = 0; i < log_n; i++) begin
      if (log_w[i]) begin
        if (wn < en)
          chk(log_a[i] == ea[wn] && log_d[i] == ed[wn],
              $sformatf("%s R2/R3/R8/R9 write %0d", name, wn), {log_a[i], log_d[i]}, {ea[wn], ed[wn]});
        if (log_a[i] == 16'hF220 && (log_d[i] == 16'h00F0 || log_d[i] == 16'h00F3)) idx_rst = i;
        wn++;
      end else begin
        if (log_a[i] == 16'hF241 && idx240 < 0) rd241++;
        if (log_a[i] == 16'hF240) begin rd240++; idx240 = i; end
      end
    end
    chk(wn == en, {name, " R2 write count"}, wn, en);
    if (!hg) begin
      chk(rd241 == st + lo + 1, {name, " R6 first poll read count"}, rd241, st + lo + 1);
      chk(rd240 == 1 && idx240 < idx_rst, {name, " R7 single status read before R9 reset"}, idx240, idx_rst);
      chk(pass == !sv[10] && err == sv[10] && !tmo, {name, " R7 outcome"}, {pass, err, tmo}, {!sv[10], sv[10], 1'b0});
    end else begin
      chk(tmo && !pass && !err, {name, " R10 timeout flag"}, {pass, err, tmo}, 3'b001);
      chk(rd240 == 0 && idx_rst < 0, {name, " R10 no status read or reset"}, rd240, 0);
    end
    @(negedge clk);
    chk(!done && !busy, {name, " R11 done single pulse"}, {done, busy}, 0);
    repeat (5) @(negedge clk);
    chk(pass == (!hg && !sv[10]) && err == (!hg && sv[10]) && tmo == hg,
        {name, " R11 flags held"}, {pass, err, tmo}, {!hg && !sv[10], !hg && sv[10], hg});
  endtask

  task automatic t_reset();
    chk(!busy && !done && !pass && !err && !tmo && !dready && !bwe && !bre,
        "R1 reset state", {busy, done, pass, err, tmo, dready, bwe, bre}, 0);
  endtask

  task automatic t_basic();      // also R12: start pulsed mid-run
    run_op(0, 0, 0, 16'h0000, 0, 0, 3, 0, 0, 1, "basic");
  endtask
  task automatic t_err_auto();   // R5 gaps, R8 auto, R3/R9 other selects
    run_op(1, 1, 1, 16'h0400, 2, 0, 1, 0, 1, 0, "err_auto");
  endtask
  task automatic t_stale();      // R6 stale high ignored
    run_op(0, 0, 1, 16'hFBFF, 1, 2, 2, 0, 1, 0, "stale");
  endtask
  task automatic t_timeout();    // R10
    lim = 16'd40;
    run_op(1, 0, 0, 16'h0000, 0, 0, 1, 1, 0, 0, "timeout");
    lim = 16'd1000;
  endtask
  task automatic t_after_tmo();  // R11 cleared by next start
    run_op(0, 1, 0, 16'h0000, 3, 1, 1, 0, 0, 0, "after_tmo");
  endtask

  initial begin
    for (int k = 0; k < NW; k++) words[k] = 16'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_err_auto();
    t_stale();
    t_timeout();
    t_after_tmo();
    finish_all();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog global", 0, 1);
    finish_all();
  end
endmodule